// File: doc/BRIEF.md
# Latency-Weighted Bank Quota Balancer

This block takes the number of tensor patches that classification assigned to each of four memory banks and evens the work out across the cluster groups. Patches stay where they were allocated. The block only decides how many of each bank's patches are handed to the clusters sitting next to other, underloaded banks. The share a far group receives shrinks as its distance to the source bank grows, because each weight is the reciprocal of a latency modelled as one plus the hop count from a programmable table.

A job is launched with a one-cycle `start`, which captures the counts and the hop table. An internal sequencer walks every source/destination pair through one shared divider. It then writes a 4x4 quota matrix at once and flags the result with a one-cycle `done`. Row `s` of the matrix tells the clusters how many of bank `s`'s patches each group serves. The entry on the diagonal is the part kept by the bank's own clusters.

Top module: `lb_balancer`

## Requirements
- R1: While `rst_n` is low, and after its release until the first job completes, `busy` and `done` are 0 and every quota entry is 0.
- R2: With N the sum of the four counts (bank b at `bank_cnt[10b +: 10]`), the target is ceil(N/4). A bank is overloaded when its count exceeds the target and underloaded when its count is below it. An off-diagonal entry (s,d) is nonzero only when s is overloaded and d is underloaded.
- R3: The hop count from source s to the clusters of bank d sits at `hop_tab[(4s+d)*3 +: 3]`. The weight is floor(840/(1+hop)). When every hop is 0, all underloaded banks and the source itself receive equal shares.
- R4: For an overloaded s and an underloaded d ≠ s, entry (s,d), found at `quota[(4s+d)*10 +: 10]`, equals floor(cnt_s · w_sd / W_s). W_s is w_ss plus the weights w_sd of every underloaded d ≠ s.
- R5: The diagonal entry (s,s) is cnt_s minus the sum of row s's off-diagonal entries. For a bank that is not overloaded it equals cnt_s.
- R6: When `done` is high, the sum of all 16 quota entries equals N.
- R7: A `start` seen while idle is accepted at that clock edge. `busy` is high from the next cycle on. `done` is a single-cycle pulse after the 17th rising edge following the accepting edge, and `busy` is low when `done` rises.
- R8: `start` pulses and changes of `bank_cnt` or `hop_tab` while `busy` is high have no effect. The result depends only on the values captured at the accepting edge.
- R9: The quota outputs change only together with a `done` pulse. They hold their value between pulses, including while a new job runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a job when the block is idle |
| bank_cnt | input | 40 | Per-bank patch counts, bank b at bits 10b+9:10b |
| hop_tab | input | 48 | Hop counts, entry 4s+d at bits (4s+d)*3+2:(4s+d)*3 |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse: the quota matrix is new and valid |
| quota | output | 160 | Quota matrix, entry 4s+d at bits (4s+d)*10+9:(4s+d)*10 |

## Verification
The balancing function is tried with four kinds of load:
- An already even load shows that nothing moves when no bank exceeds the target.
- All patches on one bank, under ring, chain and irregular hop tables, show that the split follows the reciprocal latency and that the remainder stays on the source bank.
- Two overloaded banks feeding two light ones show that sources are handled independently against a shared set of targets.
- A total not divisible by four, and a load off by one from even, probe the ceiling target and the strict over/under comparison.

All-zero hops separate weight handling from classification, since the split must then be exactly equal. The count at the field maximum exposes any product or divider that is too narrow.

// File: rtl/lb_pkg.sv
package lb_pkg;

    typedef enum logic [1:0] {
        LB_IDLE    = 2'd0,
        LB_RUN     = 2'd1,
        LB_PUBLISH = 2'd2
    } lb_state_e;

    // reciprocal-latency weight: latency modelled as one plus the hop count
    function automatic int unsigned lb_weight(input int unsigned scale, input int unsigned hops);
        return scale / (hops + 1);
    endfunction

endpackage

// File: rtl/lb_classify.sv
module lb_classify #(
    parameter int NB    = 4,
    parameter int CNT_W = 10,
    parameter int TOT_W = 13
) (
    input  logic [NB-1:0][CNT_W-1:0] cnt,
    output logic [NB-1:0]            over,
    output logic [NB-1:0]            under
);
    logic [TOT_W-1:0] total;
    logic [TOT_W-1:0] target;

    always_comb begin
        total = '0;
        for (int i = 0; i < NB; i++) begin
            total = total + TOT_W'(cnt[i]);
        end
    end

    assign target = (total + TOT_W'(NB - 1)) / TOT_W'(NB);

    for (genvar b = 0; b < NB; b++) begin : g_cls
        assign over[b]  = TOT_W'(cnt[b]) > target;
        assign under[b] = TOT_W'(cnt[b]) < target;
    end
endmodule

// File: rtl/lb_weight_gen.sv
module lb_weight_gen #(
    parameter int NB     = 4,
    parameter int HOP_W  = 3,
    parameter int WSCALE = 840,
    parameter int WGT_W  = 10,
    parameter int WSUM_W = 12
) (
    input  logic [NB-1:0][NB-1:0][HOP_W-1:0] hop,
    input  logic [NB-1:0]                    under,
    output logic [NB-1:0][NB-1:0][WGT_W-1:0] wgt,
    output logic [NB-1:0][WSUM_W-1:0]        wsum
);
    for (genvar s = 0; s < NB; s++) begin : g_src
        for (genvar d = 0; d < NB; d++) begin : g_dst
            assign wgt[s][d] = WGT_W'(lb_pkg::lb_weight(WSCALE, 32'(hop[s][d])));
        end

        // pool of a source: its own clusters plus every underloaded bank
        always_comb begin
            wsum[s] = WSUM_W'(wgt[s][s]);
            for (int d = 0; d < NB; d++) begin
                if (d != s && under[d]) begin
                    wsum[s] = wsum[s] + WSUM_W'(wgt[s][d]);
                end
            end
        end
    end
endmodule

// File: rtl/lb_share_calc.sv
module lb_share_calc #(
    parameter int CNT_W  = 10,
    parameter int WGT_W  = 10,
    parameter int WSUM_W = 12
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [WGT_W-1:0]  wgt,
    input  logic [WSUM_W-1:0] wsum,
    input  logic              en,
    output logic [CNT_W-1:0]  share
);
    localparam int PROD_W = CNT_W + WGT_W;
    localparam int DIV_W  = (PROD_W > WSUM_W) ? PROD_W : WSUM_W;

    logic [DIV_W-1:0] prod;
    logic [DIV_W-1:0] quo;

    assign prod  = DIV_W'(cnt) * DIV_W'(wgt);
    assign quo   = (wsum == '0) ? '0 : prod / DIV_W'(wsum);
    // quotient never exceeds cnt because wgt <= wsum
    assign share = en ? CNT_W'(quo) : '0;
endmodule

// File: rtl/lb_balancer.sv
module lb_balancer #(
    parameter int NB     = 4,
    parameter int CNT_W  = 10,
    parameter int HOP_W  = 3,
    parameter int WSCALE = 840
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NB*CNT_W-1:0]        bank_cnt,
    input  logic [NB*NB*HOP_W-1:0]     hop_tab,
    output logic                       busy,
    output logic                       done,
    output logic [NB*NB*CNT_W-1:0]     quota
);
    import lb_pkg::*;

    localparam int SEL_W  = (NB > 1) ? $clog2(NB) : 1;
    localparam int TOT_W  = CNT_W + $clog2(NB) + 1;
    localparam int WGT_W  = $clog2(WSCALE + 1);
    localparam int WSUM_W = $clog2(NB * WSCALE + 1);

    typedef struct packed {
        lb_state_e                         state;
        logic [SEL_W-1:0]                  src;
        logic [SEL_W-1:0]                  dst;
        logic [NB-1:0][CNT_W-1:0]          cnt;
        logic [NB-1:0][NB-1:0][HOP_W-1:0]  hop;
        logic [NB-1:0][NB-1:0][CNT_W-1:0]  work;
        logic [NB-1:0][NB-1:0][CNT_W-1:0]  quota;
        logic                              done;
    } lb_regs_t;

    lb_regs_t r_q, r_d;

    logic [NB-1:0]                    over_m, under_m;
    logic [NB-1:0][NB-1:0][WGT_W-1:0] wgt;
    logic [NB-1:0][WSUM_W-1:0]        wsum;
    logic [CNT_W-1:0]                 share_cur;
    logic                             pair_en;
    logic [CNT_W-1:0]                 moved;
    logic [NB*CNT_W-1:0]              cnt_lat;

    lb_classify #(.NB(NB), .CNT_W(CNT_W), .TOT_W(TOT_W)) u_cls (
        .cnt   (r_q.cnt),
        .over  (over_m),
        .under (under_m)
    );

    lb_weight_gen #(.NB(NB), .HOP_W(HOP_W), .WSCALE(WSCALE),
                    .WGT_W(WGT_W), .WSUM_W(WSUM_W)) u_wgt (
        .hop   (r_q.hop),
        .under (under_m),
        .wgt   (wgt),
        .wsum  (wsum)
    );

    assign pair_en = over_m[r_q.src] && under_m[r_q.dst] && (r_q.src != r_q.dst);

    lb_share_calc #(.CNT_W(CNT_W), .WGT_W(WGT_W), .WSUM_W(WSUM_W)) u_div (
        .cnt   (r_q.cnt[r_q.src]),
        .wgt   (wgt[r_q.src][r_q.dst]),
        .wsum  (wsum[r_q.src]),
        .en    (pair_en),
        .share (share_cur)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        moved    = '0;
        case (r_q.state)
            LB_IDLE: begin
                if (start) begin
                    r_d.state = LB_RUN;
                    r_d.src   = '0;
                    r_d.dst   = '0;
                    r_d.cnt   = bank_cnt;
                    r_d.hop   = hop_tab;
                end
            end
            LB_RUN: begin
                r_d.work[r_q.src][r_q.dst] = share_cur;
                if (r_q.dst == SEL_W'(NB - 1)) begin
                    r_d.dst = '0;
                    if (r_q.src == SEL_W'(NB - 1)) begin
                        r_d.state = LB_PUBLISH;
                    end else begin
                        r_d.src = r_q.src + 1'b1;
                    end
                end else begin
                    r_d.dst = r_q.dst + 1'b1;
                end
            end
            LB_PUBLISH: begin
                for (int s = 0; s < NB; s++) begin
                    moved = '0;
                    for (int d = 0; d < NB; d++) begin
                        if (d != s) begin
                            moved = moved + r_q.work[s][d];
                        end
                    end
                    r_d.quota[s]    = r_q.work[s];
                    r_d.quota[s][s] = r_q.cnt[s] - moved;
                end
                r_d.done  = 1'b1;
                r_d.state = LB_IDLE;
            end
            default: r_d.state = LB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.state != LB_IDLE);
    assign done    = r_q.done;
    assign quota   = r_q.quota;
    assign cnt_lat = r_q.cnt;
endmodule

// File: rtl/lb_balancer_chk.sv
module lb_balancer_chk #(
    parameter int NB    = 4,
    parameter int CNT_W = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic [NB*NB*CNT_W-1:0] quota,
    input logic [NB*CNT_W-1:0]    cnt_lat
);
    localparam int SUM_W = CNT_W + 2 * $clog2(NB) + 1;

    logic [SUM_W-1:0] quota_sum, cnt_sum;

    always_comb begin
        quota_sum = '0;
        cnt_sum   = '0;
        for (int i = 0; i < NB * NB; i++) begin
            quota_sum = quota_sum + SUM_W'(quota[i*CNT_W +: CNT_W]);
        end
        for (int i = 0; i < NB; i++) begin
            cnt_sum = cnt_sum + SUM_W'(cnt_lat[i*CNT_W +: CNT_W]);
        end
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7
    finish_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    capture_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cnt_lat));

    // R9
    quota_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(quota));

    // R6
    quota_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (quota_sum == cnt_sum));
endmodule

bind lb_balancer lb_balancer_chk #(.NB(NB), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .quota   (quota),
    .cnt_lat (cnt_lat)
);

// File: tb/lb_balancer_bench.sv
`timescale 1ns/1ps
module lb_balancer_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [39:0]  bank_cnt;
    logic [47:0]  hop_tab;
    logic         busy;
    logic         done;
    logic [159:0] quota;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    lb_balancer u_lb_balancer (
        .clk(clk), .rst_n(rst_n), .start(start), .bank_cnt(bank_cnt),
        .hop_tab(hop_tab), .busy(busy), .done(done), .quota(quota)
    );

    localparam logic [63:0] HOP_RING  = 64'h0121_1012_2101_1210;
    localparam logic [63:0] HOP_CHAIN = 64'h0123_1012_2101_3210;
    localparam logic [63:0] HOP_ZERO  = 64'h0;
    localparam logic [63:0] HOP_ODD   = 64'h7654_3210_0716_2345;

    localparam int NV = 9;
    localparam logic [39:0] VCNT [NV] = '{
        {10'd100, 10'd100, 10'd100, 10'd100},
        {10'd400, 10'd0,   10'd0,   10'd0},
        {10'd300, 10'd300, 10'd10,  10'd10},
        {10'd0,   10'd0,   10'd0,   10'd7},
        {10'd0,   10'd0,   10'd0,   10'd1023},
        {10'd5,   10'd3,   10'd1,   10'd900},
        {10'd250, 10'd249, 10'd251, 10'd250},
        {10'd1,   10'd0,   10'd0,   10'd0},
        {10'd0,   10'd0,   10'd0,   10'd0}
    };
    localparam logic [63:0] VHOP [NV] = '{
        HOP_RING, HOP_RING, HOP_CHAIN, HOP_CHAIN, HOP_ODD,
        HOP_ZERO, HOP_ODD, HOP_RING, HOP_CHAIN
    };

    function automatic logic [47:0] hop_pack(input logic [63:0] n);
        logic [47:0] r;
        for (int i = 0; i < 16; i++) r[i*3 +: 3] = n[i*4 +: 3];
        return r;
    endfunction

    function automatic int cnt_of(input logic [39:0] c, input int b);
        return int'(c[b*10 +: 10]);
    endfunction

    function automatic int q_of(input logic [159:0] q, input int s, input int d);
        return int'(q[(s*4+d)*10 +: 10]);
    endfunction

    // expected matrix from the requirements
    function automatic logic [159:0] model(input logic [39:0] c, input logic [63:0] hn);
        logic [159:0] r;
        int tot, tgt, ws, acc, sh;
        int w [4][4];
        r   = '0;
        tot = 0;
        for (int b = 0; b < 4; b++) tot += cnt_of(c, b);
        tgt = (tot + 3) / 4;
        for (int s = 0; s < 4; s++)
            for (int d = 0; d < 4; d++)
                w[s][d] = 840 / (1 + int'(hn[(s*4+d)*4 +: 4]));
        for (int s = 0; s < 4; s++) begin
            acc = 0;
            if (cnt_of(c, s) > tgt) begin
                ws = w[s][s];
                for (int d = 0; d < 4; d++)
                    if (d != s && cnt_of(c, d) < tgt) ws += w[s][d];
                for (int d = 0; d < 4; d++) begin
                    if (d != s && cnt_of(c, d) < tgt) begin
                        sh = cnt_of(c, s) * w[s][d] / ws;
                        r[(s*4+d)*10 +: 10] = 10'(sh);
                        acc += sh;
                    end
                end
            end
            r[(s*4+s)*10 +: 10] = 10'(cnt_of(c, s) - acc);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [159:0] act,
                         input logic [159:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    // drives one job; lat counts rising edges from the accepting edge up to done
    task automatic run_job(input logic [39:0] c, input logic [63:0] hn,
                           output int lat, output bit busy_early, output bit busy_at_done);
        @(negedge clk);
        bank_cnt = c;
        hop_tab  = hop_pack(hn);
        start    = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        lat        = 1;
        busy_early = busy;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        busy_at_done = busy;
    endtask

    function automatic int qsum(input logic [159:0] q);
        int t = 0;
        for (int i = 0; i < 16; i++) t += int'(q[i*10 +: 10]);
        return t;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int lat;
        bit be, bd;
        logic [159:0] exp, held;

        rst_n = 1'b0; start = 1'b0; bank_cnt = '0; hop_tab = '0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(busy == 1'b0 && done == 1'b0 && quota == '0, "R1 in reset",
              {busy, done, quota}, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 after release
        check(busy == 1'b0 && done == 1'b0 && quota == '0, "R1 after release",
              {busy, done, quota}, '0);

        for (int v = 0; v < NV; v++) begin
            int tot, tgt;
            bit clean;
            run_job(VCNT[v], VHOP[v], lat, be, bd);
            exp = model(VCNT[v], VHOP[v]);
            check(quota == exp, $sformatf("R4 R5 vector %0d", v), quota, exp);
            tot = 0;
            for (int b = 0; b < 4; b++) tot += cnt_of(VCNT[v], b);
            check(qsum(quota) == tot, $sformatf("R6 vector %0d", v), qsum(quota), tot);
            check(lat == 18 && be && !bd, $sformatf("R7 vector %0d", v),
                  {lat, be, bd}, {32'd18, 1'b1, 1'b0});
            tgt = (tot + 3) / 4;
            clean = 1'b1;
            for (int s = 0; s < 4; s++)
                for (int d = 0; d < 4; d++)
                    if (d != s && q_of(quota, s, d) != 0 &&
                        !(cnt_of(VCNT[v], s) > tgt && cnt_of(VCNT[v], d) < tgt))
                        clean = 1'b0;
            check(clean, $sformatf("R2 vector %0d", v), quota, exp);
            @(negedge clk);
            check(done == 1'b0, $sformatf("R7 pulse width vector %0d", v), done, 0);
        end

        // R3 hand values: chain hops, 7 patches on bank 0 -> 5 kept, 1, 1, 0 moved
        run_job(VCNT[3], VHOP[3], lat, be, bd);
        check(q_of(quota,0,0) == 5 && q_of(quota,0,1) == 1 && q_of(quota,0,2) == 1 &&
              q_of(quota,0,3) == 0, "R3 inverse latency split", quota[39:0],
              {10'd0, 10'd1, 10'd1, 10'd5});

        // R3 all hops zero: 900 split in four equal parts of 225
        run_job(VCNT[5], VHOP[5], lat, be, bd);
        check(q_of(quota,0,0) == 225 && q_of(quota,0,1) == 225 && q_of(quota,0,2) == 225 &&
              q_of(quota,0,3) == 225, "R3 equal hops equal split", quota[39:0],
              {10'd225, 10'd225, 10'd225, 10'd225});

        // R8: second start and input changes during a job are ignored
        @(negedge clk);
        bank_cnt = VCNT[1]; hop_tab = hop_pack(VHOP[1]); start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat = 1;
        repeat (4) begin @(negedge clk); lat++; end
        bank_cnt = VCNT[2]; hop_tab = hop_pack(VHOP[2]); start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0; bank_cnt = VCNT[4];
        while (!done && lat < 60) begin @(negedge clk); lat++; end
        exp = model(VCNT[1], VHOP[1]);
        check(quota == exp, "R8 result from captured inputs", quota, exp);
        check(lat == 18, "R8 job not restarted", lat, 18);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R8 no second job queued", busy, 0);

        // R9: quotas hold while idle with changing inputs and during a new job
        held = quota;
        bank_cnt = VCNT[6]; hop_tab = hop_pack(VHOP[6]);
        repeat (25) @(negedge clk);
        check(quota == held && done == 1'b0, "R9 hold while idle", quota, held);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (9) @(negedge clk);
        check(busy == 1'b1 && quota == held, "R9 hold during job", quota, held);
        while (!done) @(negedge clk);
        exp = model(VCNT[6], VHOP[6]);
        check(quota == exp, "R9 new result published", quota, exp);

        // R1 reset in the middle of a job clears everything
        run_job(VCNT[2], VHOP[2], lat, be, bd);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && quota == '0, "R1 mid-job reset",
              {busy, done, quota}, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finish_run();
    end
endmodule